// File: doc/BRIEF.md
# Low-Power Wake-Up Level Detector

This block decides when a device leaves normal operation for one of its reduced-power modes and when it comes back. Software programs two 8-bit configuration registers through a simple write port. One picks the reduced-power mode. The other arms wake-up and sets a priority threshold. When the processor reports that it has halted and wake-up is armed, the block moves into the selected mode and drops the matching clock-gate enables.

While a reduced-power mode is held, a purely combinational path watches the unmasked interrupt request level of every source. It raises the exit request at once if any source presents the top level (7), or a level strictly above the programmed threshold. It does not wait for any gated clock to do this. The block runs on a free-running clock. On the first edge of that clock that sees the exit request, it returns to run mode, and all clock enables come back on.

Top module: `lpwake_ctrl`

## Requirements
- R1: After reset the mode output is run (0), all three clock enables are 1, the exit request is 0, wake-up is disarmed, the threshold is 0 and the selected mode is run.
- R2: A halt indication received in run mode while wake-up is disarmed leaves the block in run mode with all clocks enabled.
- R3: A halt indication received in run mode while wake-up is armed moves the mode output to the selected mode on the next clock edge when that selection is not run. The selection is encoded as 0 run, 1 wait, 2 doze and 3 stop.
- R4: When the selected mode is run, a halt indication leaves the block in run mode even if wake-up is armed.
- R5: The core clock enable is 1 only in run mode. The system clock enable is 1 in run and wait. The peripheral clock enable is 0 only in stop.
- R6: The exit request is 0 in run mode whatever the request levels are.
- R7: In any reduced-power mode, a source at level 7 raises the exit request in the same cycle, whatever the threshold is, including a threshold of 7.
- R8: In any reduced-power mode, a source whose level is strictly greater than the threshold raises the exit request in the same cycle. A level equal to the threshold does not, and level 0 means no request.
- R9: An exit request returns the mode output to run on the next clock edge, which restores all clock enables.
- R10: A halt indication received while already in a reduced-power mode does not change the mode, even after the mode selection has been rewritten.
- R11: Register map. A write with select 0 stores the mode selection in data bits [1:0]. A write with select 1 stores the wake-up enable in bit 7 and the threshold in bits [2:0]. A write takes effect from the next cycle, so a halt in the same cycle as the write uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 mode selection, 1 wake-up control |
| cfg_wdata | input | 8 | Write data |
| cpu_halted | input | 1 | Processor reports it has halted |
| irq_lvls | input | NUM_SRC*3 (24) | Unmasked request level per source, 0 meaning idle |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System bus clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| lp_mode | output | 2 | Current mode: 0 run, 1 wait, 2 doze, 3 stop |
| wake_req | output | 1 | Request to leave the reduced-power mode |

## Verification
The hardest cases to reach are those where two things happen in the same cycle. In one, a register write and a halt indication arrive together. In another, a halt indication arrives while the block is already parked, just after the mode selection was rewritten. In a third, a request level sits exactly on the threshold. The stimulus reaches these with directed sequences that park the block in each mode first and then drive the colliding inputs in one cycle. A sweep then enters doze for every pair of threshold and level, placing the level on a different source each time. A behavioural model compares all outputs every cycle.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [1:0] {
    LPM_RUN  = 2'd0,
    LPM_WAIT = 2'd1,
    LPM_DOZE = 2'd2,
    LPM_STOP = 2'd3
  } lpm_e;

  typedef struct packed {
    logic per;
    logic sys;
    logic core;
  } clk_gates_t;

  // Clock enables that stay on in a given mode; deeper modes switch off more.
  function automatic clk_gates_t gates_for(input lpm_e m);
    clk_gates_t g;
    g.core = (m == LPM_RUN);
    g.sys  = (m == LPM_RUN) || (m == LPM_WAIT);
    g.per  = (m != LPM_STOP);
    return g;
  endfunction

  function automatic logic is_low_power(input lpm_e m);
    return m != LPM_RUN;
  endfunction

endpackage

// File: rtl/lpw_cfg_regs.sv
module lpw_cfg_regs
  import lpw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output lpm_e              mode_sel,
  output logic              wake_en,
  output logic [LVL_W-1:0]  wake_thr
);

  localparam int EN_BIT = DATA_W - 1;

  lpm_e             mode_q;
  logic             en_q;
  logic [LVL_W-1:0] thr_q;

  logic wr_mode;
  logic wr_wake;

  assign wr_mode = we && !sel;
  assign wr_wake = we && sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= LPM_RUN;
    end else if (wr_mode) begin
      mode_q <= lpm_e'(wdata[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= '0;
    end else if (wr_wake) begin
      en_q  <= wdata[EN_BIT];
      thr_q <= wdata[LVL_W-1:0];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata[EN_BIT-1:LVL_W];

  assign mode_sel = mode_q;
  assign wake_en  = en_q;
  assign wake_thr = thr_q;

endmodule

// File: rtl/lpw_level_eval.sv
module lpw_level_eval #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3
) (
  input  logic                     armed,
  input  logic [LVL_W-1:0]         thr,
  input  logic [NUM_SRC*LVL_W-1:0] lvls,
  output logic [NUM_SRC-1:0]       src_hit,
  output logic                     hit
);

  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

  // A level qualifies when it is the top level or strictly above the threshold.
  function automatic logic qualifies(input logic [LVL_W-1:0] lvl,
                                     input logic [LVL_W-1:0] t);
    return (lvl == TOP_LVL) || (lvl > t);
  endfunction

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [LVL_W-1:0] lvl;
    assign lvl        = lvls[s*LVL_W +: LVL_W];
    assign src_hit[s] = (lvl != '0) && qualifies(lvl, thr);
  end

  assign hit = armed && (|src_hit);

endmodule

// File: rtl/lpw_mode_fsm.sv
module lpw_mode_fsm
  import lpw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halted,
  input  logic wake_en,
  input  lpm_e mode_sel,
  input  logic wake_hit,
  output lpm_e cur_mode,
  output logic enter_evt,
  output logic exit_evt
);

  lpm_e mode_q;
  lpm_e mode_d;

  assign enter_evt = !is_low_power(mode_q) && halted && wake_en && is_low_power(mode_sel);
  assign exit_evt  = is_low_power(mode_q) && wake_hit;

  always_comb begin
    mode_d = mode_q;
    if (enter_evt) begin
      mode_d = mode_sel;
    end else if (exit_evt) begin
      mode_d = LPM_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= LPM_RUN;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign cur_mode = mode_q;

endmodule

// File: rtl/lpw_clk_gates.sv
module lpw_clk_gates
  import lpw_pkg::*;
(
  input  lpm_e mode,
  output logic core_en,
  output logic sys_en,
  output logic per_en
);

  clk_gates_t g;

  assign g       = gates_for(mode);
  assign core_en = g.core;
  assign sys_en  = g.sys;
  assign per_en  = g.per;

endmodule

// File: rtl/lpwake_ctrl.sv
module lpwake_ctrl
  import lpw_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int DATA_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_sel,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic                     cpu_halted,
  input  logic [NUM_SRC*LVL_W-1:0] irq_lvls,
  output logic                     core_clk_en,
  output logic                     sys_clk_en,
  output logic                     per_clk_en,
  output logic [1:0]               lp_mode,
  output logic                     wake_req
);

  lpm_e             mode_sel;
  logic             wake_en;
  logic [LVL_W-1:0] wake_thr;
  lpm_e             cur_mode;
  logic             armed;
  logic [NUM_SRC-1:0] src_hit;
  logic             wake_hit;
  logic             enter_evt;
  logic             exit_evt;

  lpw_cfg_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .mode_sel (mode_sel),
    .wake_en  (wake_en),
    .wake_thr (wake_thr)
  );

  assign armed = is_low_power(cur_mode);

  lpw_level_eval #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_eval (
    .armed   (armed),
    .thr     (wake_thr),
    .lvls    (irq_lvls),
    .src_hit (src_hit),
    .hit     (wake_hit)
  );

  lpw_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .halted    (cpu_halted),
    .wake_en   (wake_en),
    .mode_sel  (mode_sel),
    .wake_hit  (wake_hit),
    .cur_mode  (cur_mode),
    .enter_evt (enter_evt),
    .exit_evt  (exit_evt)
  );

  lpw_clk_gates u_gates (
    .mode    (cur_mode),
    .core_en (core_clk_en),
    .sys_en  (sys_clk_en),
    .per_en  (per_clk_en)
  );

  assign lp_mode  = cur_mode;
  assign wake_req = wake_hit;

endmodule

// File: rtl/lpw_checker.sv
module lpw_checker #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_SRC*LVL_W-1:0] irq_lvls,
  input logic                     wake_en,
  input logic                     enter_evt,
  input logic                     core_clk_en,
  input logic [1:0]               lp_mode,
  input logic                     wake_req
);

  function automatic logic any_top(input logic [NUM_SRC*LVL_W-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (v[i*LVL_W +: LVL_W] == {LVL_W{1'b1}}) r = 1'b1;
    end
    return r;
  endfunction

  assert_no_wake_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode == 2'd0) |-> !wake_req);

  assert_top_level_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_mode != 2'd0) && any_top(irq_lvls)) |-> wake_req);

  assert_exit_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> (lp_mode == 2'd0));

  assert_disarmed_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_mode == 2'd0) && !wake_en) |=> (lp_mode == 2'd0));

  assert_parked_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_mode != 2'd0) && !wake_req) |=> $stable(lp_mode));

  assert_core_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode != 2'd0) |-> !core_clk_en);

  assert_entry_leaves_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> (lp_mode != 2'd0));

endmodule

bind lpwake_ctrl lpw_checker #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_lvls    (irq_lvls),
  .wake_en     (wake_en),
  .enter_evt   (enter_evt),
  .core_clk_en (core_clk_en),
  .lp_mode     (lp_mode),
  .wake_req    (wake_req)
);

// File: tb/test_lpwake_ctrl.sv
`timescale 1ns/1ps
module test_lpwake_ctrl;

  localparam int NS = 8;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic          cpu_halted = 1'b0;
  logic [NS*LW-1:0] irq_lvls = '0;
  logic          core_clk_en, sys_clk_en, per_clk_en, wake_req;
  logic [1:0]    lp_mode;

  always #5 clk = ~clk;

  lpwake_ctrl #(.NUM_SRC(NS), .LVL_W(LW), .DATA_W(8)) i_lpwake_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cpu_halted(cpu_halted), .irq_lvls(irq_lvls),
    .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .per_clk_en(per_clk_en),
    .lp_mode(lp_mode), .wake_req(wake_req)
  );

  // Behavioural reference state
  int m_mode, m_sel, m_thr;
  bit m_en;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string tag = "R1";

  function automatic bit exp_wake();
    if (m_mode == 0) return 0;
    for (int i = 0; i < NS; i++) begin
      int l;
      l = int'(irq_lvls[i*LW +: LW]);
      if (l == 7) return 1;
      if (l != 0 && l > m_thr) return 1;
    end
    return 0;
  endfunction

  task automatic cmp(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("lp_mode", int'(lp_mode), m_mode);
    cmp("core_clk_en", int'(core_clk_en), (m_mode == 0) ? 1 : 0);
    cmp("sys_clk_en", int'(sys_clk_en), (m_mode < 2) ? 1 : 0);
    cmp("per_clk_en", int'(per_clk_en), (m_mode != 3) ? 1 : 0);
    cmp("wake_req", int'(wake_req), int'(exp_wake()));
  endtask

  // One cycle: inputs already applied at the falling edge; model follows the
  // rising edge, then outputs are compared at the next falling edge.
  task automatic cycle();
    bit w;
    @(posedge clk);
    #1;
    w = exp_wake();
    if (!rst_n) begin
      m_mode = 0; m_sel = 0; m_thr = 0; m_en = 0;
    end else begin
      if (m_mode == 0) begin
        if (cpu_halted && m_en && m_sel != 0) m_mode = m_sel;
      end else if (w) begin
        m_mode = 0;
      end
      if (cfg_we && !cfg_sel) m_sel = int'(cfg_wdata[1:0]);
      if (cfg_we && cfg_sel) begin
        m_en  = cfg_wdata[7];
        m_thr = int'(cfg_wdata[2:0]);
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    cfg_we = 0; cpu_halted = 0;
    cycle();
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d; cpu_halted = 0;
    cycle();
    cfg_we = 0;
  endtask

  task automatic halt();
    cpu_halted = 1;
    cycle();
    cpu_halted = 0;
  endtask

  task automatic set_lvl(int src, int lvl);
    irq_lvls[src*LW +: LW] = LW'(lvl);
  endtask

  initial begin
    m_mode = 0; m_sel = 0; m_thr = 0; m_en = 0;
    @(negedge clk);
    tag = "R1";
    repeat (3) cycle();
    rst_n = 1;
    cycle();
    // R1: explicit reset-state checks
    cmp("reset lp_mode R1", int'(lp_mode), 0);
    cmp("reset wake_req R1", int'(wake_req), 0);

    // R2: disarmed, stop selected, halt -> stays run
    tag = "R2";
    wr(0, 8'h03);
    wr(1, 8'h03);
    set_lvl(2, 5);
    halt();
    idle();
    cmp("disarmed lp_mode R2", int'(lp_mode), 0);

    // R6: top level present in run mode, no exit request
    tag = "R6";
    set_lvl(4, 7);
    idle();
    cmp("run wake_req R6", int'(wake_req), 0);
    irq_lvls = '0;

    // R4: armed but run selected
    tag = "R4";
    wr(0, 8'h00);
    wr(1, 8'h83);
    halt();
    idle();
    cmp("run selected R4", int'(lp_mode), 0);

    // R3/R5/R8/R9: wait mode, level equal to threshold then above
    tag = "R3";
    wr(0, 8'hFD);          // junk in upper bits, field = wait (R11)
    halt();
    cmp("enter wait R3", int'(lp_mode), 1);
    tag = "R5";
    cmp("wait sys gate R5", int'(sys_clk_en), 1);
    tag = "R8";
    set_lvl(1, 3);
    idle();
    cmp("equal level R8", int'(wake_req), 0);
    set_lvl(6, 4);
    #1;
    cmp("above level R8", int'(wake_req), 1);
    tag = "R9";
    idle();
    cmp("exit to run R9", int'(lp_mode), 0);
    cmp("core back on R9", int'(core_clk_en), 1);
    irq_lvls = '0;
    idle();

    // R7: doze with threshold 7, level 6 ignored, level 7 wakes
    tag = "R7";
    wr(0, 8'h02);
    wr(1, 8'h87);
    halt();
    cmp("doze entered R7", int'(lp_mode), 2);
    set_lvl(0, 6);
    idle();
    cmp("level 6 below thr 7 R7", int'(wake_req), 0);
    set_lvl(7, 7);
    #1;
    cmp("level 7 wakes R7", int'(wake_req), 1);
    idle();
    irq_lvls = '0;
    idle();

    // R10: in stop, rewrite selection and halt again: mode holds
    tag = "R10";
    wr(0, 8'h03);
    wr(1, 8'h82);
    halt();
    cmp("stop entered R10", int'(lp_mode), 3);
    tag = "R5";
    cmp("stop per gate R5", int'(per_clk_en), 0);
    tag = "R10";
    wr(0, 8'h01);
    halt();
    halt();
    cmp("halt while parked R10", int'(lp_mode), 3);
    set_lvl(7, 3);
    idle();
    idle();
    cmp("stop exit R10", int'(lp_mode), 0);
    irq_lvls = '0;

    // R11: write and halt in the same cycle, old selection (wait) used
    tag = "R11";
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 8'h02; cpu_halted = 1;
    cycle();
    cfg_we = 0; cpu_halted = 0;
    cmp("old selection used R11", int'(lp_mode), 1);
    set_lvl(3, 7);
    idle();
    irq_lvls = '0;
    idle();

    // R8/R7 sweep: every threshold/level pair in doze
    tag = "R8";
    wr(0, 8'h02);
    for (int t = 0; t < 8; t++) begin
      for (int l = 0; l < 8; l++) begin
        wr(1, 8'h80 | 8'(t));
        halt();
        set_lvl((t + l) % NS, l);
        idle();
        irq_lvls = '0;
        idle();
        if (lp_mode != 0) begin
          set_lvl(0, 7);
          idle();
          irq_lvls = '0;
          idle();
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule